// File: doc/BRIEF.md
# Programmable Flag Port with Interrupt

A sixteen-pin general-purpose flag port. Each pin is individually configured as an input or an output, and each input can raise an interrupt. Software reaches the port through a small synchronous register bus: writes take effect on the rising clock edge, and read data follows the address combinationally. Pad tristate is modelled as a separate output-enable vector and an output-data vector.

Input pins pass through a two-flop synchroniser, gated by a per-pin input-buffer enable. They are then judged either by level or by edge, with a per-pin polarity that applies to both modes. Edge events are held in capture latches until software clears them. The output data and the interrupt mask can each be changed through write-one alias registers, so no read-modify-write is needed. One interrupt line combines all pending, unmasked pins.

Register map (4-bit address): 0 data, 1 data-set, 2 data-clear (this also clears edge captures), 3 direction, 4 input enable, 5 sense (1 = edge), 6 polarity (1 = active low or falling), 7 mask, 8 mask-set, 9 mask-clear, 10 mask-toggle. Every other address reads 0.

Top module: `pflag_gpio`

## Requirements
- R1: After reset, the direction, input-enable, sense, polarity, mask and data registers read 0, `pin_oe` is 0 and `irq_a` is low.
- R2: `pin_oe` equals the direction register (bit 1 = output), and `pin_out` carries the data register.
- R3: Writing address 0 loads the data register. Writing 1 to a bit at address 1 sets that data bit, and writing 1 at address 2 clears it. Bits written as 0 at addresses 1 and 2 keep their value.
- R4: An input pin whose input-enable bit is 0 reads 0 at address 0 and never raises `irq_a`.
- R5: A change on an enabled input pin shows at address 0 after exactly two rising edges. Address 0 reads the data bit for output pins and the synchronised input for input pins.
- R6: A level-sensitive input (sense 0) raises `irq_a` while it is at its active level (high when polarity is 0, low when polarity is 1) and its mask bit is 1.
- R7: An edge-sensitive input (sense 1) latches a rising edge (polarity 0) or a falling edge (polarity 1), including a pulse that lasts one clock cycle. The latch raises `irq_a` while the mask bit is 1.
- R8: Writing 1 to a bit at address 2 clears that pin's edge latch. The interrupt it caused drops on the next cycle.
- R9: Address 7 reads and writes the mask directly. Writing 1 to a bit at address 8 sets it, at address 9 clears it, and at address 10 inverts it. Bits written as 0 keep their value.
- R10: A pin configured as an output never contributes to `irq_a`, whatever its sense, polarity, enable or pad level.
- R11: Addresses 3 to 6 read back their registers. Addresses 8 to 10 read the mask. Addresses 1 and 2 read like address 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | 16 | Pad input levels |
| pin_oe | output | 16 | Pad output enables |
| pin_out | output | 16 | Pad output data |
| irq_a | output | 1 | Interrupt request, active high |

## Verification
A wrong register bit shows up in the same cycle: on `pin_oe` or `pin_out`, or on `bus_rdata` when that address is selected. The bench compares all of these on every clock. A faulty synchroniser or edge latch shows only through timing. A level event must reach `irq_a` two edges after the pad changes, and an edge event three edges after. So a late or stuck capture appears as an `irq_a` mismatch within a few cycles of the stimulus. A latch that fails to clear keeps `irq_a` high in the cycle after the clearing write.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 4'd0,
    A_DSET  = 4'd1,
    A_DCLR  = 4'd2,
    A_DIR   = 4'd3,
    A_INEN  = 4'd4,
    A_SENSE = 4'd5,
    A_POL   = 4'd6,
    A_MASK  = 4'd7,
    A_MSET  = 4'd8,
    A_MCLR  = 4'd9,
    A_MTGL  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/pflag_rst_sync.sv
module pflag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  assign sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/pflag_sync.sv
module pflag_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] st_d;
      if (g == 0) begin : g_first
        assign st_d = d;
      end else begin : g_rest
        assign st_d = st_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else        st_q[g] <= st_d;
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pflag_regs.sv
module pflag_regs
  import pflag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      inen_q,
  output logic [W-1:0]      sense_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      cap_clr
);
  logic [W-1:0] data_d, mask_d;
  logic data_en, dir_en, inen_en, sense_en, pol_en, mask_en;

  always_comb begin
    data_d   = data_q;
    mask_d   = mask_q;
    data_en  = 1'b0;
    dir_en   = 1'b0;
    inen_en  = 1'b0;
    sense_en = 1'b0;
    pol_en   = 1'b0;
    mask_en  = 1'b0;
    cap_clr  = '0;
    if (wr_en) begin
      case (addr)
        A_DATA:  begin data_en = 1'b1; data_d = wdata;            end
        A_DSET:  begin data_en = 1'b1; data_d = data_q | wdata;   end
        A_DCLR:  begin data_en = 1'b1; data_d = data_q & ~wdata;
                       cap_clr = wdata;                           end
        A_DIR:   dir_en   = 1'b1;
        A_INEN:  inen_en  = 1'b1;
        A_SENSE: sense_en = 1'b1;
        A_POL:   pol_en   = 1'b1;
        A_MASK:  begin mask_en = 1'b1; mask_d = wdata;            end
        A_MSET:  begin mask_en = 1'b1; mask_d = mask_q | wdata;   end
        A_MCLR:  begin mask_en = 1'b1; mask_d = mask_q & ~wdata;  end
        A_MTGL:  begin mask_en = 1'b1; mask_d = mask_q ^ wdata;   end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      inen_q  <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (data_en)  data_q  <= data_d;
      if (dir_en)   dir_q   <= wdata;
      if (inen_en)  inen_q  <= wdata;
      if (sense_en) sense_q <= wdata;
      if (pol_en)   pol_q   <= wdata;
      if (mask_en)  mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/pflag_irq.sv
module pflag_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] inen,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] cap_clr,
  output logic [W-1:0] in_vis,
  output logic         irq
);
  logic [W-1:0] prev_q, cap_q, cap_d;
  logic [W-1:0] live, act_now, act_prev, edge_hit, pend;

  assign live     = inen & ~dir;
  assign in_vis   = smp & live;
  assign act_now  = smp ^ pol;
  assign act_prev = prev_q ^ pol;
  assign edge_hit = live & sense & act_now & ~act_prev;
  assign cap_d    = (cap_q & ~cap_clr) | edge_hit;
  assign pend     = (live & ~sense & act_now) | (live & sense & cap_q);
  assign irq      = |(pend & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= smp;
      cap_q  <= cap_d;
    end
  end
endmodule

// File: rtl/pflag_gpio.sv
module pflag_gpio
  import pflag_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic              irq_a
);
  logic srst_n;
  logic [NPINS-1:0] smp, data_q, dir_q, inen_q, sense_q, pol_q, mask_q;
  logic [NPINS-1:0] cap_clr, in_vis, data_view;

  pflag_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  pflag_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pin_in), .q(smp));

  pflag_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q), .inen_q(inen_q),
    .sense_q(sense_q), .pol_q(pol_q), .mask_q(mask_q), .cap_clr(cap_clr));

  pflag_irq #(.W(NPINS)) u_irq (
    .clk(clk), .rst_n(srst_n), .smp(smp), .dir(dir_q), .inen(inen_q),
    .sense(sense_q), .pol(pol_q), .mask(mask_q), .cap_clr(cap_clr),
    .in_vis(in_vis), .irq(irq_a));

  assign pin_oe    = dir_q;
  assign pin_out   = data_q;
  assign data_view = (data_q & dir_q) | in_vis;

  always_comb begin
    case (bus_addr)
      A_DATA, A_DSET, A_DCLR:         bus_rdata = data_view;
      A_DIR:                          bus_rdata = dir_q;
      A_INEN:                         bus_rdata = inen_q;
      A_SENSE:                        bus_rdata = sense_q;
      A_POL:                          bus_rdata = pol_q;
      A_MASK, A_MSET, A_MCLR, A_MTGL: bus_rdata = mask_q;
      default:                        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pflag_gpio_chk.sv
module pflag_gpio_chk
  import pflag_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  inen_q,
  input logic [NPINS-1:0]  dir_q,
  input logic              irq_a
);
  // R9
  mask_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == A_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R9
  mask_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == A_MCLR) |=> ((mask_q & $past(bus_wdata)) == '0));
  // R3
  data_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == A_DSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  data_clr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == A_DCLR) |=> ((pin_out & $past(bus_wdata)) == '0));
  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq_a |-> ((inen_q & ~dir_q & mask_q) != '0));
endmodule

bind pflag_gpio pflag_gpio_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .mask_q(mask_q),
  .inen_q(inen_q), .dir_q(dir_q), .irq_a(irq_a));

// File: tb/tb_pflag_gpio.sv
`timescale 1ns/1ps
module tb_pflag_gpio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out;
  logic        irq_a;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pflag_gpio dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq_a(irq_a));

  // behavioural reference model
  logic [15:0] m_data, m_dir, m_inen, m_sense, m_pol, m_mask, m_cap, m_s1, m_s2, m_prev;
  int m_rc;

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] lv, ed, cl;
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_inen = 0; m_sense = 0; m_pol = 0; m_mask = 0;
      m_cap = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_rc = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      lv = m_inen & ~m_dir;
      ed = lv & m_sense & (m_s2 ^ m_pol) & ~(m_prev ^ m_pol);
      cl = (bus_we && bus_addr == 4'd2) ? bus_wdata : 16'h0;
      m_cap = (m_cap & ~cl) | ed;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_we) begin
        case (bus_addr)
          4'd0: m_data = bus_wdata;
          4'd1: m_data = m_data | bus_wdata;
          4'd2: m_data = m_data & ~bus_wdata;
          4'd3: m_dir = bus_wdata;
          4'd4: m_inen = bus_wdata;
          4'd5: m_sense = bus_wdata;
          4'd6: m_pol = bus_wdata;
          4'd7: m_mask = bus_wdata;
          4'd8: m_mask = m_mask | bus_wdata;
          4'd9: m_mask = m_mask & ~bus_wdata;
          4'd10: m_mask = m_mask ^ bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic m_irq();
    logic [15:0] lv;
    lv = m_inen & ~m_dir;
    return |((((lv & ~m_sense & (m_s2 ^ m_pol)) | (lv & m_sense & m_cap))) & m_mask);
  endfunction

  function automatic logic [15:0] m_rd(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2: return (m_data & m_dir) | (m_s2 & m_inen & ~m_dir);
      4'd3: return m_dir;
      4'd4: return m_inen;
      4'd5: return m_sense;
      4'd6: return m_pol;
      4'd7, 4'd8, 4'd9, 4'd10: return m_mask;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_n && m_rc == 2 && !done) begin
      chk("R2 model pin_oe", pin_oe, m_dir);
      chk("R3 model pin_out", pin_out, m_data);
      chk("R6 model irq_a", {15'h0, irq_a}, {15'h0, m_irq()});
      chk("R11 model bus_rdata", bus_rdata, m_rd(bus_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    rd(4'd3, v); chk("R1 dir", v, 16'h0);
    rd(4'd4, v); chk("R1 inen", v, 16'h0);
    rd(4'd7, v); chk("R1 mask", v, 16'h0);
    rd(4'd5, v); chk("R1 sense", v, 16'h0);
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 irq", {15'h0, irq_a}, 16'h0);
    // R2 and R3
    wr(4'd3, 16'h00FF);
    wr(4'd0, 16'h0F0F);
    #1; chk("R2 oe", pin_oe, 16'h00FF); chk("R2 out", pin_out, 16'h0F0F);
    wr(4'd1, 16'h00F0);
    #1; chk("R3 set", pin_out, 16'h0FFF);
    wr(4'd2, 16'h0003);
    #1; chk("R3 clr", pin_out, 16'h0FFC);
    // R4 disabled inputs
    pin_in = 16'hFF00;
    wr(4'd7, 16'hFFFF);
    cyc(3);
    rd(4'd0, v); chk("R4 read", v, 16'h00FC);
    chk("R4 irq", {15'h0, irq_a}, 16'h0);
    // R5 and R6 level, active high
    pin_in = 16'h0000;
    wr(4'd4, 16'hFF00);
    cyc(3);
    chk("R6 idle", {15'h0, irq_a}, 16'h0);
    bus_addr = 4'd0;
    pin_in = 16'h0100;
    @(negedge clk); #1;
    chk("R5 one edge", bus_rdata, 16'h00FC);
    chk("R6 not yet", {15'h0, irq_a}, 16'h0);
    @(negedge clk); #1;
    chk("R5 two edges", bus_rdata, 16'h01FC);
    chk("R6 high level", {15'h0, irq_a}, 16'h1);
    // R6 active low
    wr(4'd6, 16'h0100);
    #1; chk("R6 pol inactive", {15'h0, irq_a}, 16'h0);
    pin_in = 16'h0000;
    cyc(2); #1;
    chk("R6 low level", {15'h0, irq_a}, 16'h1);
    wr(4'd6, 16'h0000);
    cyc(1);
    // R7 one-cycle rising pulse on pin 9
    wr(4'd5, 16'h0200);
    pin_in = 16'h0200;
    @(negedge clk);
    pin_in = 16'h0000;
    cyc(5); #1;
    chk("R7 rising latched", {15'h0, irq_a}, 16'h1);
    // R8 clear
    wr(4'd2, 16'h0200);
    #1; chk("R8 cleared", {15'h0, irq_a}, 16'h0);
    // R7 falling edge
    wr(4'd6, 16'h0200);
    pin_in = 16'h0200;
    cyc(4); #1;
    chk("R7 rise ignored", {15'h0, irq_a}, 16'h0);
    pin_in = 16'h0000;
    cyc(4); #1;
    chk("R7 falling latched", {15'h0, irq_a}, 16'h1);
    wr(4'd2, 16'h0200);
    #1; chk("R8 cleared again", {15'h0, irq_a}, 16'h0);
    // R9 mask aliases on level pin 8
    wr(4'd6, 16'h0000);
    pin_in = 16'h0100;
    cyc(3); #1;
    chk("R9 base irq", {15'h0, irq_a}, 16'h1);
    wr(4'd9, 16'h0100);
    #1; chk("R9 mclr irq", {15'h0, irq_a}, 16'h0);
    rd(4'd7, v); chk("R9 mclr read", v, 16'hFEFF);
    wr(4'd10, 16'h0101);
    rd(4'd7, v); chk("R9 mtgl read", v, 16'hFFFE);
    #1; chk("R9 mtgl irq", {15'h0, irq_a}, 16'h1);
    wr(4'd8, 16'h0001);
    rd(4'd8, v); chk("R9 mset read", v, 16'hFFFF);
    wr(4'd7, 16'h0100);
    rd(4'd7, v); chk("R9 direct", v, 16'h0100);
    // R10 output pins ignored
    pin_in = 16'h0000;
    wr(4'd7, 16'h00FF);
    wr(4'd4, 16'hFFFF);
    wr(4'd6, 16'h00F0);
    wr(4'd5, 16'h000F);
    pin_in = 16'h00FF;
    cyc(2);
    pin_in = 16'h0000;
    cyc(2);
    pin_in = 16'h00AA;
    cyc(4); #1;
    chk("R10 irq", {15'h0, irq_a}, 16'h0);
    rd(4'd0, v); chk("R10 read drives", v, 16'h00FC);
    // R11 map
    rd(4'd5, v); chk("R11 sense", v, 16'h000F);
    rd(4'd6, v); chk("R11 pol", v, 16'h00F0);
    rd(4'd15, v); chk("R11 unmapped", v, 16'h0);
    rd(4'd2, v); chk("R11 dclr alias", v, 16'h00FC);
    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule